// File: doc/BRIEF.md
# Flash TDC Statistical Calibration Counter

This block measures a flash time-to-digital converter statistically, with no external instruments. While the converter's data edge is swept against its clock, a start pulse opens a window of exactly 2^WIN_LOG2 clock cycles. In every cycle of that window the block samples the converter's flip-flop vector. It counts the cycles in which one chosen stage reads high. It also keeps four aggregate counters: some stage high, every stage high, some stage low and every stage low.

When the window closes, every counter freezes and a done flag stays set. A host can then read the counts at leisure. The host repeats the window once for each stage index, so every stage's figure can be read on its own. From those figures it derives the delay of each stage, sorts them and scales them to time.

Two differences are also given while done is set. The some-high count minus the every-high count gives the in-range events from the high side. The some-low count minus the every-low count gives the in-range events from the low side.

Top module: `tdc_cal_counter`

## Requirements
- R1: After reset every counter and both difference outputs are zero, and busy_o and done_o are low.
- R2: A start_i pulse without clear_i clears all counters, captures sel_i and raises busy_o on the same edge. ref_cnt_o then counts the window cycles.
- R3: A window samples stage_i on exactly 2^WIN_LOG2 consecutive edges after the start edge. On the last of those edges busy_o falls, done_o rises and ref_cnt_o equals 2^WIN_LOG2. done_o stays high until the next start or clear.
- R4: stage_cnt_o counts the sampled cycles in which bit number sel (the index captured at start, counted from bit 0) of stage_i is 1.
- R5: Four counters hold the number of sampled cycles in which stage_i is, in turn, not all zeros (any_hi_o), all ones (all_hi_o), not all ones (any_lo_o) and all zeros (all_lo_o).
- R6: Each counter is WIN_LOG2+1 bits wide, so a count equal to the full window length of 2^WIN_LOG2 is held without wrapping.
- R7: A change of sel_i while busy_o is high does not alter which stage is counted.
- R8: While done_o is high, hi_range_o = any_hi_o - all_hi_o and lo_range_o = any_lo_o - all_lo_o. At all other times both outputs are zero.
- R9: clear_i zeroes all counters and drops busy_o and done_o. It wins over a start_i given on the same edge.
- R10: After the window closes, changes on stage_i leave every count unchanged.
- R11: A start_i pulse during an active window restarts it from a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear the counters and open a window |
| clear_i | input | 1 | Clear the counters and return to idle |
| sel_i | input | SEL_W | Index of the stage to count, captured at start |
| stage_i | input | N_STAGES | Flip-flop outputs of the converter |
| busy_o | output | 1 | Window is active |
| done_o | output | 1 | Window has finished and the counts are frozen |
| ref_cnt_o | output | CNT_W | Reference cycle count |
| stage_cnt_o | output | CNT_W | High count of the selected stage |
| any_hi_o | output | CNT_W | Cycles with at least one stage high |
| all_hi_o | output | CNT_W | Cycles with every stage high |
| any_lo_o | output | CNT_W | Cycles with at least one stage low |
| all_lo_o | output | CNT_W | Cycles with every stage low |
| hi_range_o | output | CNT_W | In-range events, high side (zero unless done) |
| lo_range_o | output | CNT_W | In-range events, low side (zero unless done) |

## Verification
The bench builds the block with N_STAGES = 4 and WIN_LOG2 = 4. This gives a 16-cycle window, which is exactly the number of distinct stage vectors. One window can therefore present every vector once, and the full-count case (16 in a 5-bit counter) is reached directly.

Five stimulus patterns are each run against every stage index, for twenty windows. Every expected count is tallied in the bench as it drives each vector. The bench also checks a selection change mid-window, changes on stage_i after done, a restart mid-window, and clear, both alone and together with start.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
  // event lanes fed to the accumulators
  typedef enum int unsigned {
    EV_SEL    = 0,
    EV_ANY_HI = 1,
    EV_ALL_HI = 2,
    EV_ANY_LO = 3,
    EV_ALL_LO = 4
  } ev_lane_e;
  localparam int unsigned EV_N = 5;
endpackage

// File: rtl/tdc_cal_window.sv
module tdc_cal_window #(
  parameter int unsigned WIN_LOG2 = 20,
  parameter int unsigned CNT_W    = WIN_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] ref_cnt_o
);
  localparam logic [CNT_W-1:0] WinLen  = CNT_W'(1) << WIN_LOG2;
  localparam logic [CNT_W-1:0] WinLast = WinLen - CNT_W'(1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] ref_q;
  logic             last;

  assign launch_o = start_i & ~clear_i;
  assign last     = busy_q & (ref_q == WinLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ref_q  <= '0;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ref_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      ref_q  <= '0;
    end else if (busy_q) begin
      ref_q <= ref_q + CNT_W'(1);
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ref_cnt_o = ref_q;

  // R3
  ref_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q <= WinLen);
  // R3
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i && !clear_i) |=> done_q);
  // R3
  done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (ref_q == WinLen));
  // R9
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!busy_q && !done_q && ref_q == '0));
endmodule

// File: rtl/tdc_cal_evt.sv
module tdc_cal_evt
  import tdc_cal_pkg::*;
#(
  parameter int unsigned N_STAGES = 32,
  parameter int unsigned SEL_W    = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                busy_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [N_STAGES-1:0] stage_i,
  output logic [EV_N-1:0]     hit_o
);
  logic [SEL_W-1:0] sel_q;

  // index is captured only at launch; mid-window changes are ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (launch_i) sel_q <= sel_i;
  end

  always_comb begin
    hit_o            = '0;
    hit_o[EV_SEL]    = stage_i[sel_q];
    hit_o[EV_ANY_HI] = |stage_i;
    hit_o[EV_ALL_HI] = &stage_i;
    hit_o[EV_ANY_LO] = ~&stage_i;
    hit_o[EV_ALL_LO] = ~|stage_i;
  end

  // R7
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !launch_i) |=> $stable(sel_q));
endmodule

// File: rtl/tdc_cal_acc.sv
module tdc_cal_acc #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + CNT_W'(1);
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tdc_cal_counter.sv
module tdc_cal_counter
  import tdc_cal_pkg::*;
#(
  parameter int unsigned N_STAGES = 32,
  parameter int unsigned WIN_LOG2 = 20,
  parameter int unsigned SEL_W    = (N_STAGES > 1) ? $clog2(N_STAGES) : 1,
  parameter int unsigned CNT_W    = WIN_LOG2 + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                clear_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [N_STAGES-1:0] stage_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    ref_cnt_o,
  output logic [CNT_W-1:0]    stage_cnt_o,
  output logic [CNT_W-1:0]    any_hi_o,
  output logic [CNT_W-1:0]    all_hi_o,
  output logic [CNT_W-1:0]    any_lo_o,
  output logic [CNT_W-1:0]    all_lo_o,
  output logic [CNT_W-1:0]    hi_range_o,
  output logic [CNT_W-1:0]    lo_range_o
);
  logic                 launch, busy, done;
  logic [EV_N-1:0]      hit;
  logic [CNT_W-1:0]     cnt [EV_N];

  tdc_cal_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) i_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .clear_i  (clear_i),
    .launch_o (launch),
    .busy_o   (busy),
    .done_o   (done),
    .ref_cnt_o(ref_cnt_o)
  );

  tdc_cal_evt #(.N_STAGES(N_STAGES), .SEL_W(SEL_W)) i_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .busy_i  (busy),
    .sel_i   (sel_i),
    .stage_i (stage_i),
    .hit_o   (hit)
  );

  for (genvar k = 0; k < EV_N; k++) begin : g_acc
    tdc_cal_acc #(.CNT_W(CNT_W)) i_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clear_i | launch),
      .en_i  (busy & hit[k]),
      .cnt_o (cnt[k])
    );
  end

  assign busy_o      = busy;
  assign done_o      = done;
  assign stage_cnt_o = cnt[EV_SEL];
  assign any_hi_o    = cnt[EV_ANY_HI];
  assign all_hi_o    = cnt[EV_ALL_HI];
  assign any_lo_o    = cnt[EV_ANY_LO];
  assign all_lo_o    = cnt[EV_ALL_LO];
  assign hi_range_o  = done ? (cnt[EV_ANY_HI] - cnt[EV_ALL_HI]) : '0;
  assign lo_range_o  = done ? (cnt[EV_ANY_LO] - cnt[EV_ALL_LO]) : '0;

  // R5
  hi_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_hi_o <= any_hi_o);
  // R5
  lo_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_lo_o <= any_lo_o);
  // R10
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !start_i && !clear_i) |=> ($stable(stage_cnt_o) && $stable(any_hi_o)
      && $stable(all_hi_o) && $stable(any_lo_o) && $stable(all_lo_o)));
  // R8
  range_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |-> (hi_range_o == '0 && lo_range_o == '0));
  // R2
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i) |=> (busy && stage_cnt_o == '0 && any_hi_o == '0
      && all_lo_o == '0));
  // R3
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && done));
endmodule

// File: tb/test_tdc_cal_counter.sv
module test_tdc_cal_counter;
  localparam int N   = 4;
  localparam int WL  = 4;
  localparam int WIN = 1 << WL;
  localparam int SW  = 2;
  localparam int CW  = WL + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          clear = 1'b0;
  logic [SW-1:0] sel = '0;
  logic [N-1:0]  stage = '0;
  logic          busy, done;
  logic [CW-1:0] ref_cnt, stage_cnt, any_hi, all_hi, any_lo, all_lo, hi_rng, lo_rng;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tdc_cal_counter #(.N_STAGES(N), .WIN_LOG2(WL)) i_tdc_cal_counter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clear_i(clear),
    .sel_i(sel), .stage_i(stage), .busy_o(busy), .done_o(done),
    .ref_cnt_o(ref_cnt), .stage_cnt_o(stage_cnt), .any_hi_o(any_hi),
    .all_hi_o(all_hi), .any_lo_o(any_lo), .all_lo_o(all_lo),
    .hi_range_o(hi_rng), .lo_range_o(lo_rng)
  );

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  function automatic logic [N-1:0] pat(int mode, int i);
    case (mode)
      0: return N'(i);
      1: return N'(~i);
      2: return '1;
      3: return '0;
      default: return N'((i * 5 + 3) % 16);
    endcase
  endfunction

  task automatic run_window(int mode, int s);
    int e_sel = 0, e_ah = 0, e_hh = 0, e_al = 0, e_ll = 0;
    @(negedge clk);
    start = 1'b1;
    sel   = SW'(s);
    for (int i = 0; i < WIN; i++) begin
      logic [N-1:0] p;
      @(negedge clk);
      start = 1'b0;
      if (i == 3) begin
        chk("R2 busy in window", int'(busy), 1);
        chk("R8 hi range zero mid window", int'(hi_rng), 0);
        chk("R3 done low mid window", int'(done), 0);
      end
      if (i == WIN / 2) sel = SW'(s ^ 1); // R7 mid-window change
      p = pat(mode, i);
      stage = p;
      if (p[s]) e_sel++;
      if (p != '0) e_ah++;
      if (p == '1) e_hh++;
      if (p != '1) e_al++;
      if (p == '0) e_ll++;
    end
    @(negedge clk);
    chk("R3 done", int'(done), 1);
    chk("R3 busy low", int'(busy), 0);
    chk("R3 ref count", int'(ref_cnt), WIN);
    chk("R4 R7 stage count", int'(stage_cnt), e_sel);
    chk("R5 any high", int'(any_hi), e_ah);
    chk("R5 R6 all high", int'(all_hi), e_hh);
    chk("R5 any low", int'(any_lo), e_al);
    chk("R5 R6 all low", int'(all_lo), e_ll);
    chk("R8 hi range", int'(hi_rng), e_ah - e_hh);
    chk("R8 lo range", int'(lo_rng), e_al - e_ll);
    // R10: stage_i toggling after done
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      stage = N'(j * 7 + mode);
    end
    @(negedge clk);
    chk("R10 frozen stage count", int'(stage_cnt), e_sel);
    chk("R10 frozen any high", int'(any_hi), e_ah);
    chk("R3 done held", int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset ref", int'(ref_cnt), 0);
    chk("R1 reset any high", int'(any_hi), 0);
    chk("R1 reset hi range", int'(hi_rng), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 5; m++)
      for (int s = 0; s < N; s++)
        run_window(m, s);

    // R2: start clears the frozen counts
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 ref cleared", int'(ref_cnt), 0);
    chk("R2 any low cleared", int'(any_lo), 0);
    chk("R2 busy set", int'(busy), 1);

    // R11: restart mid-window with all-ones activity, then an all-zeros window
    stage = '1;
    repeat (5) @(negedge clk);
    chk("R11 partial all high", int'(all_hi), 5);
    run_window(3, 0);

    // R9: clear mid-window
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stage = '1;
    repeat (4) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk("R9 busy cleared", int'(busy), 0);
    chk("R9 ref cleared", int'(ref_cnt), 0);
    chk("R9 all high cleared", int'(all_hi), 0);
    repeat (3) @(negedge clk);
    chk("R9 stays idle", int'(any_hi), 0);

    // R9: clear beats start
    start = 1'b1;
    clear = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clear = 1'b0;
    chk("R9 clear wins busy", int'(busy), 0);
    chk("R9 clear wins done", int'(done), 0);
    @(negedge clk);
    chk("R9 no counting", int'(any_hi), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule